// File: doc/BRIEF.md
# Bus Controller Instruction Sequencer

This block is the program engine of a serial-bus controller. It walks a list of two-word instructions held in a synchronous instruction memory. The first word carries a condition selector and an opcode. The second word is a parameter. Each conditional instruction is tested against a flag set before it takes effect. The flag set holds eight host-writable general-purpose flags, four comparison flags and the message engine's status bits. When the test fails, the instruction falls through to the next one.

The sequencer can jump, and it can call and return through a bounded hardware stack. It can halt and it can raise interrupt bits. It can compare a parameter against the frame or message time counts. It can wait on a delay timer or on the frame counter reaching zero. It also hands message block addresses to an external message engine, then stalls until that engine reports completion. The host starts the program at an address of its choosing and may rewrite the general-purpose flags at any moment.

Top module: `bcseq_top`

## Requirements
- R1: After reset `running`, `msg_start`, `dly_start`, `irq_bits`, `err_illegal`, `err_stack`, `gp_flags` and `cmp_flags` are all zero, and nothing executes until `host_start` is pulsed while idle.
- R2: A `host_start` pulse loads the program counter from `host_start_addr`. Every instruction is two words: the word at the counter holds the condition code in bits 15:8 and the opcode in bits 7:0, and the next word holds the parameter. Execution then advances by two words.
- R3: Condition codes are 0x00 always, 0x01 never, 0x02+i general flag i (i=0..7), 0x0A less-than, 0x0B greater-or-equal, 0x0C equal, 0x0D not-equal, and 0x0E+i engine status bit i (i=0..6). Any other code tests false. A false test leaves every output and flag untouched and moves to the next instruction.
- R4: Opcode 0x02 (jump) loads the counter from the parameter when its condition holds.
- R5: Opcode 0x03 (call) pushes the address of the following instruction and jumps to the parameter. Opcode 0x04 (return) resumes at the popped address. Nesting up to DEPTH=4 levels works.
- R6: A taken call while DEPTH entries are stacked, or a taken return with an empty stack, sets `err_stack` and stops the program.
- R7: Opcode 0x07 (halt) stops the program until the next `host_start`. A new start clears both error flags and empties the stack.
- R8: Opcode 0x06 (interrupt) pulses `irq_bits` for one cycle with parameter bits 3:0, so `irq_bits[i]` corresponds to interrupt status bit i+2. Upper parameter bits are ignored, and a zero low nibble gives no pulse.
- R9: Opcode 0x01 (execute message) pulses `msg_start` for one cycle with `msg_addr` equal to the parameter. No later instruction runs before `msg_done` is seen.
- R10: Execute message is never started by the engine-status condition codes 0x0E..0x14 and falls through instead. Those codes still gate other opcodes normally.
- R11: Opcodes 0x0A and 0x0B compare the parameter P with `frame_time` or `msg_time` respectively, whatever their condition code. `cmp_flags` bits {3:NE, 2:EQ, 1:GE, 0:LT} become 1001 for P less than the time, 0110 for P equal to it, and 1010 for P greater.
- R12: Opcode 0x08 (delay) pulses `dly_start` with `dly_value` equal to the parameter and waits for `dly_done`. Opcode 0x09 waits until `frame_time` is zero.
- R13: Any opcode value other than those listed sets `err_illegal` and stops the program.
- R14: `host_gp_we` loads `gp_flags` from `host_gp_wdata` in any state, including while the sequencer is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Start pulse, honoured while idle |
| host_start_addr | input | AW | First instruction address |
| host_gp_we | input | 1 | General flag write enable |
| host_gp_wdata | input | 8 | General flag write value |
| imem_addr | output | AW | Instruction memory read address |
| imem_rdata | input | 16 | Instruction memory data, one cycle after address |
| msg_start | output | 1 | Message request pulse |
| msg_addr | output | 16 | Message control block address |
| msg_done | input | 1 | Message engine completion pulse |
| eng_status | input | NST | Message engine status bits |
| frame_time | input | 16 | Frame time count |
| msg_time | input | 16 | Message time count |
| dly_start | output | 1 | Delay request pulse |
| dly_value | output | 16 | Delay length |
| dly_done | input | 1 | Delay expiry pulse |
| irq_bits | output | 4 | Interrupt set pulse, bit i maps to status bit i+2 |
| running | output | 1 | Program active |
| err_illegal | output | 1 | Undefined opcode seen |
| err_stack | output | 1 | Call stack overflow or underflow |
| gp_flags | output | 8 | General-purpose flags |
| cmp_flags | output | 4 | Comparison flags {NE,EQ,GE,LT} |

## Verification
The hardest state to reach from the ports is a stack that is exactly full when one more call arrives. The stimulus builds a program whose nested calls reach the full depth, unwinds the stack, and then runs a second program that adds one more level. Interleaving is also hard to bring about. The host writes a flag while the sequencer is stalled on an outstanding message, and the next instruction's condition depends on that flag. The bench model holds `msg_done` back for many cycles so this window stays open long enough to write into.

// File: rtl/bcseq_pkg.sv
package bcseq_pkg;
    localparam int WORD_W = 16;

    localparam logic [7:0] OP_XEQ = 8'h01;
    localparam logic [7:0] OP_JMP = 8'h02;
    localparam logic [7:0] OP_CAL = 8'h03;
    localparam logic [7:0] OP_RTN = 8'h04;
    localparam logic [7:0] OP_IRQ = 8'h06;
    localparam logic [7:0] OP_HLT = 8'h07;
    localparam logic [7:0] OP_DLY = 8'h08;
    localparam logic [7:0] OP_WFT = 8'h09;
    localparam logic [7:0] OP_CFT = 8'h0A;
    localparam logic [7:0] OP_CMT = 8'h0B;

    localparam logic [7:0] CC_ALWAYS = 8'h00;
    localparam logic [7:0] CC_NEVER  = 8'h01;
    localparam logic [7:0] CC_GP0    = 8'h02;
    localparam logic [7:0] CC_CMP0   = 8'h0A;
    localparam logic [7:0] CC_ST0    = 8'h0E;

    localparam int GP_N  = 8;
    localparam int CMP_N = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_OP, S_PAR, S_EXEC, S_MSG, S_DLY, S_WFT
    } seq_st_e;
endpackage

// File: rtl/bcseq_cond.sv
module bcseq_cond
    import bcseq_pkg::*;
#(
    parameter int NST = 7
) (
    input  logic [7:0]       code,
    input  logic [GP_N-1:0]  gp,
    input  logic [CMP_N-1:0] cmp,
    input  logic [NST-1:0]   st,
    input  logic             xeq_mode,
    output logic             take
);
    always_comb begin
        take = (code == CC_ALWAYS);
        for (int i = 0; i < GP_N; i++) begin
            if (code == CC_GP0 + 8'(i)) take = gp[i];
        end
        for (int i = 0; i < CMP_N; i++) begin
            if (code == CC_CMP0 + 8'(i)) take = cmp[i];
        end
        for (int i = 0; i < NST; i++) begin
            if (code == CC_ST0 + 8'(i)) take = st[i] & ~xeq_mode;
        end
    end
endmodule

// File: rtl/bcseq_cmp.sv
module bcseq_cmp
    import bcseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     ref_val,
    input  logic [W-1:0]     cur_val,
    output logic [CMP_N-1:0] flags
);
    logic lt, eq;
    always_comb begin
        lt    = ref_val < cur_val;
        eq    = ref_val == cur_val;
        flags = {~eq, eq, ~lt, lt};
    end
endmodule

// File: rtl/bcseq_stack.sv
module bcseq_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [SPW-1:0]           sp;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [IW-1:0] top_idx;

    always_comb begin
        stk_d = stk_q;
        if (clr) begin
            stk_d.sp = '0;
        end else if (push) begin
            stk_d.ent[stk_q.sp[IW-1:0]] = wdata;
            stk_d.sp = stk_q.sp + SPW'(1);
        end else if (pop) begin
            stk_d.sp = stk_q.sp - SPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    always_comb begin
        top_idx = IW'(stk_q.sp - SPW'(1));
        rdata   = stk_q.ent[top_idx];
        full    = (stk_q.sp == SPW'(DEPTH));
        empty   = (stk_q.sp == '0);
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.sp <= SPW'(DEPTH));
endmodule

// File: rtl/bcseq_top.sv
module bcseq_top
    import bcseq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 4,
    parameter int NST   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_start,
    input  logic [AW-1:0]     host_start_addr,
    input  logic              host_gp_we,
    input  logic [GP_N-1:0]   host_gp_wdata,
    output logic [AW-1:0]     imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              msg_start,
    output logic [WORD_W-1:0] msg_addr,
    input  logic              msg_done,
    input  logic [NST-1:0]    eng_status,
    input  logic [WORD_W-1:0] frame_time,
    input  logic [WORD_W-1:0] msg_time,
    output logic              dly_start,
    output logic [WORD_W-1:0] dly_value,
    input  logic              dly_done,
    output logic [3:0]        irq_bits,
    output logic              running,
    output logic              err_illegal,
    output logic              err_stack,
    output logic [GP_N-1:0]   gp_flags,
    output logic [CMP_N-1:0]  cmp_flags
);
    typedef struct packed {
        seq_st_e           st;
        logic [AW-1:0]     pc;
        logic [WORD_W-1:0] op;
        logic [GP_N-1:0]   gp;
        logic [CMP_N-1:0]  cmp;
        logic              e_ill;
        logic              e_stk;
        logic              msg_go;
        logic [WORD_W-1:0] msg_adr;
        logic [3:0]        irq;
        logic              dly_go;
        logic [WORD_W-1:0] dly_val;
    } seq_t;

    seq_t r_d, r_q;

    logic              take;
    logic              is_xeq;
    logic [CMP_N-1:0]  cmp_res;
    logic [WORD_W-1:0] cmp_cur;
    logic [AW-1:0]     pc_seq;
    logic [AW-1:0]     stk_top;
    logic              stk_full, stk_empty, stk_push, stk_pop, stk_clr;
    logic [7:0]        opc;
    logic [WORD_W-1:0] prm;

    assign opc    = r_q.op[7:0];
    assign prm    = imem_rdata;
    assign is_xeq = (opc == OP_XEQ);
    assign pc_seq = r_q.pc + AW'(2);
    assign cmp_cur = (opc == OP_CMT) ? msg_time : frame_time;

    bcseq_cond #(.NST(NST)) u_cond (
        .code     (r_q.op[15:8]),
        .gp       (r_q.gp),
        .cmp      (r_q.cmp),
        .st       (eng_status),
        .xeq_mode (is_xeq),
        .take     (take)
    );

    bcseq_cmp #(.W(WORD_W)) u_cmp (
        .ref_val (prm),
        .cur_val (cmp_cur),
        .flags   (cmp_res)
    );

    bcseq_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stk_clr),
        .push  (stk_push),
        .pop   (stk_pop),
        .wdata (pc_seq),
        .rdata (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_comb begin
        r_d        = r_q;
        r_d.msg_go = 1'b0;
        r_d.irq    = '0;
        r_d.dly_go = 1'b0;
        stk_push   = 1'b0;
        stk_pop    = 1'b0;
        stk_clr    = 1'b0;

        if (host_gp_we) r_d.gp = host_gp_wdata;

        case (r_q.st)
            S_IDLE: begin
                if (host_start) begin
                    r_d.st    = S_OP;
                    r_d.pc    = host_start_addr;
                    r_d.e_ill = 1'b0;
                    r_d.e_stk = 1'b0;
                    stk_clr   = 1'b1;
                end
            end
            S_OP: r_d.st = S_PAR;
            S_PAR: begin
                r_d.op = imem_rdata;
                r_d.st = S_EXEC;
            end
            S_EXEC: begin
                r_d.st = S_OP;
                r_d.pc = pc_seq;
                case (opc)
                    OP_CFT, OP_CMT: r_d.cmp = cmp_res;
                    OP_XEQ: if (take) begin
                        r_d.msg_go  = 1'b1;
                        r_d.msg_adr = prm;
                        r_d.pc      = r_q.pc;
                        r_d.st      = S_MSG;
                    end
                    OP_JMP: if (take) r_d.pc = prm[AW-1:0];
                    OP_CAL: if (take) begin
                        if (stk_full) begin
                            r_d.e_stk = 1'b1;
                            r_d.st    = S_IDLE;
                        end else begin
                            stk_push = 1'b1;
                            r_d.pc   = prm[AW-1:0];
                        end
                    end
                    OP_RTN: if (take) begin
                        if (stk_empty) begin
                            r_d.e_stk = 1'b1;
                            r_d.st    = S_IDLE;
                        end else begin
                            stk_pop = 1'b1;
                            r_d.pc  = stk_top;
                        end
                    end
                    OP_IRQ: if (take) r_d.irq = prm[3:0];
                    OP_HLT: if (take) r_d.st = S_IDLE;
                    OP_DLY: if (take) begin
                        r_d.dly_go  = 1'b1;
                        r_d.dly_val = prm;
                        r_d.pc      = r_q.pc;
                        r_d.st      = S_DLY;
                    end
                    OP_WFT: if (take) begin
                        r_d.pc = r_q.pc;
                        r_d.st = S_WFT;
                    end
                    default: begin
                        r_d.e_ill = 1'b1;
                        r_d.st    = S_IDLE;
                    end
                endcase
            end
            S_MSG: if (msg_done) begin
                r_d.st = S_OP;
                r_d.pc = pc_seq;
            end
            S_DLY: if (dly_done) begin
                r_d.st = S_OP;
                r_d.pc = pc_seq;
            end
            S_WFT: if (frame_time == '0) begin
                r_d.st = S_OP;
                r_d.pc = pc_seq;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_addr   = (r_q.st == S_PAR) ? r_q.pc + AW'(1) : r_q.pc;
    assign msg_start   = r_q.msg_go;
    assign msg_addr    = r_q.msg_adr;
    assign dly_start   = r_q.dly_go;
    assign dly_value   = r_q.dly_val;
    assign irq_bits    = r_q.irq;
    assign running     = (r_q.st != S_IDLE);
    assign err_illegal = r_q.e_ill;
    assign err_stack   = r_q.e_stk;
    assign gp_flags    = r_q.gp;
    assign cmp_flags   = r_q.cmp;

    assert_msg_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> !msg_start);
    assert_msg_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_MSG && !msg_done) |=> (running && !irq_bits[0] && $stable(r_q.pc)));
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_bits != 4'h0) |=> (irq_bits == 4'h0));
    assert_stack_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_stack) |-> !running);
    assert_illegal_halt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_illegal) |-> !running);
    assert_xeq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_EXEC && is_xeq && r_q.op[15:8] >= CC_ST0
         && r_q.op[15:8] < CC_ST0 + 8'(NST)) |=> !msg_start);
    assert_cmp_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmp_flags) == 0 || $countones(cmp_flags) == 2));
    assert_host_gp_R14: assert property (@(posedge clk) disable iff (!rst_n)
        host_gp_we |=> (gp_flags == $past(host_gp_wdata)));
endmodule

// File: tb/bcseq_top_test.sv
module bcseq_top_test;
    localparam int AW = 8;
    localparam int MSG_LAT = 15;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_start = 1'b0;
    logic [7:0]  host_start_addr = '0;
    logic        host_gp_we = 1'b0;
    logic [7:0]  host_gp_wdata = '0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata;
    logic        msg_start;
    logic [15:0] msg_addr;
    logic        msg_done = 1'b0;
    logic [6:0]  eng_status = '0;
    logic [15:0] frame_time = 16'd100;
    logic [15:0] msg_time = 16'd40;
    logic        dly_start;
    logic [15:0] dly_value;
    logic        dly_done = 1'b0;
    logic [3:0]  irq_bits;
    logic        running, err_illegal, err_stack;
    logic [7:0]  gp_flags;
    logic [3:0]  cmp_flags;

    logic [15:0] mem [0:255];
    int cyc = 0;
    int checks = 0, errors = 0;
    int msg_cnt = 0, msg_ctr = 0, msg_done_cyc = 0;
    logic [15:0] last_msg = '0;
    int dly_cnt = 0, dly_ctr = 0, dly_start_cyc = 0;
    logic [15:0] last_dly = '0;
    int irq_cnt = 0, irq_cyc = 0;
    logic [3:0] last_irq = '0;

    // {cond[32:25], gp[24:17], cft_param[16:1], expect_taken[0]}
    localparam logic [32:0] VEC [0:NV-1] = '{
        {8'h00, 8'h00, 16'd100, 1'b1},
        {8'h01, 8'hFF, 16'd100, 1'b0},
        {8'h02, 8'h01, 16'd100, 1'b1},
        {8'h02, 8'hFE, 16'd100, 1'b0},
        {8'h09, 8'h80, 16'd100, 1'b1},
        {8'h07, 8'hDF, 16'd100, 1'b0},
        {8'h0A, 8'h00, 16'd50,  1'b1},
        {8'h0A, 8'h00, 16'd100, 1'b0},
        {8'h0B, 8'h00, 16'd100, 1'b1},
        {8'h0B, 8'h00, 16'd50,  1'b0},
        {8'h0C, 8'h00, 16'd100, 1'b1},
        {8'h0C, 8'h00, 16'd150, 1'b0},
        {8'h0D, 8'h00, 16'd150, 1'b1},
        {8'h0D, 8'h00, 16'd100, 1'b0},
        {8'h0E, 8'hFF, 16'd100, 1'b0},
        {8'h20, 8'hFF, 16'd100, 1'b0}
    };

    bcseq_top uut (
        .clk(clk), .rst_n(rst_n), .host_start(host_start),
        .host_start_addr(host_start_addr), .host_gp_we(host_gp_we),
        .host_gp_wdata(host_gp_wdata), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .msg_start(msg_start), .msg_addr(msg_addr),
        .msg_done(msg_done), .eng_status(eng_status), .frame_time(frame_time),
        .msg_time(msg_time), .dly_start(dly_start), .dly_value(dly_value),
        .dly_done(dly_done), .irq_bits(irq_bits), .running(running),
        .err_illegal(err_illegal), .err_stack(err_stack),
        .gp_flags(gp_flags), .cmp_flags(cmp_flags)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        imem_rdata <= mem[imem_addr];
    end

    always @(negedge clk) begin
        msg_done = 1'b0;
        if (msg_ctr != 0) begin
            msg_ctr = msg_ctr - 1;
            if (msg_ctr == 0) begin msg_done = 1'b1; msg_done_cyc = cyc; end
        end
        if (msg_start) begin msg_cnt++; last_msg = msg_addr; msg_ctr = MSG_LAT; end
        dly_done = 1'b0;
        if (dly_ctr != 0) begin
            dly_ctr = dly_ctr - 1;
            if (dly_ctr == 0) dly_done = 1'b1;
        end
        if (dly_start) begin
            dly_cnt++; last_dly = dly_value; dly_ctr = int'(dly_value); dly_start_cyc = cyc;
        end
        if (irq_bits != 4'h0) begin irq_cnt++; last_irq = irq_bits; irq_cyc = cyc; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] cc,
                       input logic [7:0] op, input logic [15:0] p);
        mem[a] = {cc, op};
        mem[a + 8'd1] = p;
    endtask

    task automatic write_gp(input logic [7:0] v);
        @(negedge clk);
        host_gp_we = 1'b1; host_gp_wdata = v;
        @(negedge clk);
        host_gp_we = 1'b0;
    endtask

    task automatic run_prog(input logic [7:0] sa);
        @(negedge clk);
        host_start_addr = sa; host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        repeat (2) @(negedge clk);
        for (int n = 0; n < 5000 && running; n++) @(negedge clk);
        chk("program completes", 32'(running), 32'h0);
    endtask

    function automatic logic [3:0] exp_cmp(input logic [15:0] p, input logic [15:0] t);
        if (p < t) return 4'b1001;
        if (p == t) return 4'b0110;
        return 4'b1010;
    endfunction

    task automatic run_all();
        int i0, m0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 running", 32'(running), 0);
        chk("R1 outputs", {msg_start, dly_start, irq_bits, err_illegal, err_stack}, 0);
        chk("R1 flags", {gp_flags, cmp_flags}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle without start", 32'(running), 0);

        // R3 R11 condition vector walk
        for (int v = 0; v < NV; v++) begin
            logic [7:0] cc; logic [7:0] g; logic [15:0] cp; logic ex;
            {cc, g, cp, ex} = VEC[v];
            write_gp(g);
            clear_mem();
            put(8'd0, 8'h01, 8'h0A, cp);   // compare with never code: unconditional
            put(8'd2, cc, 8'h06, 16'h0006);
            put(8'd4, 8'h00, 8'h07, 16'h0);
            i0 = irq_cnt;
            run_prog(8'd0);
            chk($sformatf("R11 cmp flags vec %0d", v), 32'(cmp_flags), 32'(exp_cmp(cp, 16'd100)));
            chk($sformatf("R3 taken vec %0d", v), 32'(irq_cnt - i0), 32'(ex));
            if (ex) chk($sformatf("R8 irq bits vec %0d", v), 32'(last_irq), 32'h6);
            chk("R3 no error", {err_illegal, err_stack}, 0);
        end

        // R11 message time compare
        clear_mem();
        put(8'd0, 8'h00, 8'h0B, 16'd40);
        put(8'd2, 8'h00, 8'h07, 16'h0);
        run_prog(8'd0);
        chk("R11 msg time equal", 32'(cmp_flags), 32'h6);

        // R2 R4 start address and jumps
        clear_mem();
        put(8'h40, 8'h00, 8'h02, 16'h0050);
        put(8'h42, 8'h00, 8'h06, 16'h0001);
        put(8'h50, 8'h01, 8'h02, 16'h0042);
        put(8'h52, 8'h00, 8'h06, 16'h0002);
        put(8'h54, 8'h00, 8'h07, 16'h0);
        i0 = irq_cnt;
        run_prog(8'h40);
        chk("R4 jump taken/skipped count", 32'(irq_cnt - i0), 1);
        chk("R2 R4 path irq", 32'(last_irq), 2);

        // R8 irq nibble use
        clear_mem();
        put(8'd0, 8'h00, 8'h06, 16'h00F0);
        put(8'd2, 8'h00, 8'h06, 16'hFFF9);
        put(8'd4, 8'h00, 8'h07, 16'h0);
        i0 = irq_cnt;
        run_prog(8'd0);
        chk("R8 zero nibble no pulse", 32'(irq_cnt - i0), 1);
        chk("R8 low nibble only", 32'(last_irq), 9);

        // R5 four-deep nesting
        clear_mem();
        put(8'd0,  8'h00, 8'h03, 16'd10);
        put(8'd2,  8'h00, 8'h06, 16'h0003);
        put(8'd4,  8'h00, 8'h07, 16'h0);
        put(8'd10, 8'h00, 8'h03, 16'd20);
        put(8'd12, 8'h00, 8'h04, 16'h0);
        put(8'd20, 8'h00, 8'h03, 16'd30);
        put(8'd22, 8'h00, 8'h04, 16'h0);
        put(8'd30, 8'h00, 8'h03, 16'd40);
        put(8'd32, 8'h00, 8'h04, 16'h0);
        put(8'd40, 8'h00, 8'h06, 16'h0001);
        put(8'd42, 8'h00, 8'h04, 16'h0);
        i0 = irq_cnt;
        run_prog(8'd0);
        chk("R5 depth four reached and unwound", 32'(irq_cnt - i0), 2);
        chk("R5 returned to caller", 32'(last_irq), 3);
        chk("R5 no stack error", 32'(err_stack), 0);

        // R6 overflow on fifth level
        put(8'd40, 8'h00, 8'h03, 16'd50);
        put(8'd42, 8'h00, 8'h06, 16'h0001);
        put(8'd50, 8'h00, 8'h06, 16'h0008);
        i0 = irq_cnt;
        run_prog(8'd0);
        chk("R6 overflow flag", 32'(err_stack), 1);
        chk("R6 overflow halts", 32'(irq_cnt - i0), 0);

        // R6 underflow, R3 return skipped, R7 restart clears error
        clear_mem();
        put(8'd0, 8'h01, 8'h04, 16'h0);
        put(8'd2, 8'h00, 8'h06, 16'h0001);
        put(8'd4, 8'h00, 8'h04, 16'h0);
        put(8'd6, 8'h00, 8'h06, 16'h0002);
        i0 = irq_cnt;
        run_prog(8'd0);
        chk("R6 underflow flag", 32'(err_stack), 1);
        chk("R6 R3 underflow halts", 32'(irq_cnt - i0), 1);

        // R13 illegal opcode, R7 restart clears it
        clear_mem();
        put(8'd0, 8'h00, 8'h05, 16'h0);
        put(8'd2, 8'h00, 8'h06, 16'h0001);
        i0 = irq_cnt;
        run_prog(8'd0);
        chk("R13 illegal flag", 32'(err_illegal), 1);
        chk("R13 illegal halts", 32'(irq_cnt - i0), 0);
        chk("R7 start cleared stack error", 32'(err_stack), 0);
        put(8'd0, 8'h00, 8'h07, 16'h0);
        run_prog(8'd0);
        chk("R7 start cleared illegal", 32'(err_illegal), 0);

        // R7 halt holds until next start
        clear_mem();
        put(8'd0, 8'h00, 8'h07, 16'h0);
        put(8'd2, 8'h00, 8'h06, 16'h0001);
        i0 = irq_cnt;
        run_prog(8'd0);
        repeat (20) @(negedge clk);
        chk("R7 halted stays idle", 32'(running), 0);
        chk("R7 nothing after halt", 32'(irq_cnt - i0), 0);

        // R9 message handshake and stall
        clear_mem();
        put(8'd0, 8'h00, 8'h01, 16'h1234);
        put(8'd2, 8'h00, 8'h06, 16'h0001);
        put(8'd4, 8'h00, 8'h07, 16'h0);
        m0 = msg_cnt;
        run_prog(8'd0);
        chk("R9 one request", 32'(msg_cnt - m0), 1);
        chk("R9 block address", 32'(last_msg), 32'h1234);
        chk("R9 stalled until done", 32'(irq_cyc > msg_done_cyc), 1);

        // R10 status codes cannot start a message; R14 host write while stalled
        eng_status = 7'h7F;
        write_gp(8'h00);
        clear_mem();
        put(8'd0, 8'h0E, 8'h01, 16'h0011);
        put(8'd2, 8'h14, 8'h01, 16'h0022);
        put(8'd4, 8'h0E, 8'h06, 16'h0004);
        put(8'd6, 8'h00, 8'h01, 16'h00AA);
        put(8'd8, 8'h04, 8'h06, 16'h0008);
        put(8'd10, 8'h00, 8'h07, 16'h0);
        m0 = msg_cnt; i0 = irq_cnt;
        @(negedge clk);
        host_start_addr = 8'd0; host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        for (int n = 0; n < 200 && msg_cnt == m0; n++) @(negedge clk);
        host_gp_we = 1'b1; host_gp_wdata = 8'h04;
        @(negedge clk);
        host_gp_we = 1'b0;
        chk("R14 flag written while stalled", 32'(gp_flags), 32'h04);
        for (int n = 0; n < 5000 && running; n++) @(negedge clk);
        chk("R10 only ALWAYS request issued", 32'(msg_cnt - m0), 1);
        chk("R10 address of allowed request", 32'(last_msg), 32'h00AA);
        chk("R10 R14 irq count", 32'(irq_cnt - i0), 2);
        chk("R14 flag gated irq", 32'(last_irq), 8);
        eng_status = 7'h00;

        // R12 delay
        clear_mem();
        put(8'd0, 8'h01, 8'h08, 16'd5);
        put(8'd2, 8'h00, 8'h08, 16'd30);
        put(8'd4, 8'h00, 8'h06, 16'h0001);
        put(8'd6, 8'h00, 8'h07, 16'h0);
        i0 = dly_cnt;
        run_prog(8'd0);
        chk("R12 one delay issued", 32'(dly_cnt - i0), 1);
        chk("R12 delay value", 32'(last_dly), 30);
        chk("R12 waited for expiry", 32'(irq_cyc - dly_start_cyc >= 30), 1);

        // R12 frame wait
        frame_time = 16'd5;
        clear_mem();
        put(8'd0, 8'h00, 8'h09, 16'h0);
        put(8'd2, 8'h00, 8'h06, 16'h0002);
        put(8'd4, 8'h00, 8'h07, 16'h0);
        i0 = irq_cnt;
        @(negedge clk);
        host_start_addr = 8'd0; host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R12 still waiting on frame", 32'(running), 1);
        chk("R12 no progress before zero", 32'(irq_cnt - i0), 0);
        frame_time = 16'd0;
        for (int n = 0; n < 200 && running; n++) @(negedge clk);
        chk("R12 resumed at zero", 32'(irq_cnt - i0), 1);
        frame_time = 16'd100;
    endtask

    initial begin
        clear_mem();
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule